// File: doc/BRIEF.md
# SHA-1 Message Schedule Window

This block generates the SHA-1 message schedule word for each of the 80 rounds of one 512-bit block. It does not keep all 80 expanded words. It holds sixteen 32-bit words in a window that moves forward one word per round. On each move the oldest word leaves the window, and the newly expanded word enters at the youngest end.

The compression core loads a block with a one-cycle init strobe. It then pulses the next strobe once for every round it completes. The word for the current round is always the oldest word in the window, and it is driven directly onto the output. The core can therefore read it in the same cycle in which it uses it. Padding and the round arithmetic are handled outside this block.

Top module: `sha1_sched_window`

## Requirements
- R1: While reset is asserted, and after reset until the first init, `w_o` is 0.
- R2: In the cycle after `init_i`, `w_o` equals `block_i[511:480]` as sampled at the init edge, and the internal round count is 0.
- R3: For rounds 0 to 15, the word for round t is block word t. Word t is `block_i[511-32*t -: 32]` (big-endian word order).
- R4: For rounds 16 to 79, W[t] = rotl1(W[t-3] ^ W[t-8] ^ W[t-14] ^ W[t-16]), where rotl1 rotates left by one bit.
- R5: Each cycle with `next_i` high (and `init_i` low) advances `w_o` by one round. In a cycle with neither strobe high, `w_o` keeps its value.
- R6: After 79 advances `w_o` shows W[79]. Any further `next_i` pulse has no effect, and `w_o` holds W[79].
- R7: When `init_i` and `next_i` are high in the same cycle, the init is taken and the next is ignored. The following cycle shows W[0] of the new block.
- R8: An init in the middle of a block restarts the schedule at round 0 with the new block. Nothing from the previous block remains.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Load the window from `block_i` and restart at round 0 |
| next_i | input | 1 | Advance the schedule by one round |
| block_i | input | 512 | Message block, word 0 in the top 32 bits |
| w_o | output | 32 | Schedule word for the current round |

## Verification
The hardest situation to reach is the end of the schedule. The final computed word, W[79], only appears after 79 correct advances, and every one of those words depends on words that were appended earlier. For that reason the stimulus holds `next_i` high through complete blocks and then for several cycles beyond round 79. Every one of the 80 words is compared with an 80-entry reference that the bench computes, and the bench then confirms that the value saturates. A restart in the middle of a block is forced after ten rounds, when the window holds a mix of loaded words and old positions. This shows that no stale word leaks into the new block.

// File: rtl/sha1w_pkg.sv
package sha1w_pkg;
   localparam int WORD_BITS   = 32;
   localparam int BLOCK_WORDS = 16;
   localparam int ROUND_COUNT = 80;
   // Recurrence lags, measured back from the word being produced.
   localparam int LAG_A = 3;
   localparam int LAG_B = 8;
   localparam int LAG_C = 14;
   localparam int LAG_D = 16;
endpackage

// File: rtl/sha1w_unpack.sv
module sha1w_unpack #(
   parameter int WORD_W    = 32,
   parameter int NUM_WORDS = 16,
   localparam int BLOCK_W  = WORD_W * NUM_WORDS
) (
   input  logic [BLOCK_W-1:0]                block_i,
   output logic [NUM_WORDS-1:0][WORD_W-1:0] words_o
);
   // Word 0 sits in the most significant bits of the block.
   for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
      assign words_o[i] = block_i[BLOCK_W-1-i*WORD_W -: WORD_W];
   end
endmodule

// File: rtl/sha1w_expand.sv
module sha1w_expand
   import sha1w_pkg::*;
#(
   parameter int WORD_W    = 32,
   parameter int NUM_WORDS = 16,
   parameter int ROT_AMT   = 1
) (
   input  logic [NUM_WORDS-1:0][WORD_W-1:0] win_i,
   output logic [WORD_W-1:0]                new_o
);
   localparam int TAP_A = NUM_WORDS - LAG_A;
   localparam int TAP_B = NUM_WORDS - LAG_B;
   localparam int TAP_C = NUM_WORDS - LAG_C;
   localparam int TAP_D = NUM_WORDS - LAG_D;

   if (TAP_D < 0 || TAP_C < 0 || TAP_B < 0 || TAP_A < 0) begin : g_bad_depth
      $error("window depth is shorter than the largest recurrence lag");
   end
   if (ROT_AMT < 0 || ROT_AMT >= WORD_W) begin : g_bad_rot
      $error("rotate amount out of range");
   end

   logic [WORD_W-1:0] mix;
   assign mix = win_i[TAP_A] ^ win_i[TAP_B] ^ win_i[TAP_C] ^ win_i[TAP_D];

   if (ROT_AMT == 0) begin : g_norot
      assign new_o = mix;
   end else begin : g_rot
      assign new_o = {mix[WORD_W-1-ROT_AMT:0], mix[WORD_W-1 -: ROT_AMT]};
   end
endmodule

// File: rtl/sha1w_round_ctr.sv
module sha1w_round_ctr #(
   parameter int ROUNDS = 80,
   localparam int CNT_W = $clog2(ROUNDS)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic init_i,
   input  logic next_i,
   output logic advance_o,
   output logic at_last_o
);
   if (ROUNDS < 2) begin : g_bad_rounds
      $error("round count must be at least two");
   end

   localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS - 1);

   logic [CNT_W-1:0] round_q;

   assign at_last_o = (round_q == LAST);
   assign advance_o = next_i & ~init_i & ~at_last_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         round_q <= '0;
      else if (init_i)    round_q <= '0;
      else if (advance_o) round_q <= round_q + 1'b1;
   end

   AST_ROUND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      round_q <= LAST); // R6
   AST_INIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      init_i |=> round_q == '0); // R2
   AST_LAST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (at_last_o && !init_i) |=> at_last_o); // R6
   AST_INIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (init_i && next_i) |=> round_q == '0); // R7
endmodule

// File: rtl/sha1_sched_window.sv
module sha1_sched_window
   import sha1w_pkg::*;
#(
   parameter int WORD_W    = WORD_BITS,
   parameter int NUM_WORDS = BLOCK_WORDS,
   parameter int ROUNDS    = ROUND_COUNT,
   parameter int ROT_AMT   = 1,
   localparam int BLOCK_W  = WORD_W * NUM_WORDS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               init_i,
   input  logic               next_i,
   input  logic [BLOCK_W-1:0] block_i,
   output logic [WORD_W-1:0]  w_o
);
   if (ROUNDS < NUM_WORDS) begin : g_bad_cfg
      $error("rounds must cover at least one full window");
   end

   logic [NUM_WORDS-1:0][WORD_W-1:0] load_words;
   logic [NUM_WORDS-1:0][WORD_W-1:0] win_q;
   logic [WORD_W-1:0]                new_word;
   logic                             advance;
   logic                             at_last;

   sha1w_unpack #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) u_unpack (
      .block_i (block_i),
      .words_o (load_words)
   );

   sha1w_expand #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS), .ROT_AMT(ROT_AMT)) u_expand (
      .win_i (win_q),
      .new_o (new_word)
   );

   sha1w_round_ctr #(.ROUNDS(ROUNDS)) u_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .init_i    (init_i),
      .next_i    (next_i),
      .advance_o (advance),
      .at_last_o (at_last)
   );

   // Slot 0 holds the oldest word (current round); the top slot holds the newest.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q <= '0;
      end else if (init_i) begin
         win_q <= load_words;
      end else if (advance) begin
         for (int i = 0; i < NUM_WORDS - 1; i++) begin
            win_q[i] <= win_q[i+1];
         end
         win_q[NUM_WORDS-1] <= new_word;
      end
   end

   assign w_o = win_q[0];

   AST_INIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      init_i |=> w_o == $past(block_i[BLOCK_W-1 -: WORD_W])); // R2
   AST_ADVANCE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> w_o == $past(win_q[1])); // R5
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_i && !next_i) |=> $stable(win_q)); // R5
   AST_END_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (at_last && !init_i) |=> $stable(w_o)); // R6
   AST_APPEND_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
      advance |=> win_q[NUM_WORDS-2] == $past(win_q[NUM_WORDS-1])); // R4
endmodule

// File: tb/sha1_sched_window_tb.sv
module sha1_sched_window_tb;
   localparam int NBLK = 4;
   localparam logic [511:0] BLOCKS [NBLK] = '{
      {32'h61626380, {14{32'h00000000}}, 32'h00000018},
      {16{32'h00000000}},
      {16{32'hFFFFFFFF}},
      {32'h01234567, 32'h89ABCDEF, 32'hFEDCBA98, 32'h76543210,
       32'hDEADBEEF, 32'hCAFEF00D, 32'h0BADC0DE, 32'h13579BDF,
       32'h2468ACE0, 32'h80000001, 32'h7FFFFFFE, 32'h55AA55AA,
       32'hA5A5A5A5, 32'h0F0F0F0F, 32'h00000001, 32'h80000000}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         init_i = 1'b0;
   logic         next_i = 1'b0;
   logic [511:0] block_i = '0;
   logic [31:0]  w_o;

   int checks = 0;
   int errors = 0;

   always #10ns clk = ~clk;

   sha1_sched_window u_dut (
      .clk(clk), .rst_n(rst_n), .init_i(init_i), .next_i(next_i),
      .block_i(block_i), .w_o(w_o)
   );

   function automatic logic [31:0] ref_w(input logic [511:0] b, input int t);
      logic [31:0] w [80];
      logic [31:0] x;
      for (int i = 0; i < 16; i++) w[i] = b[511-32*i -: 32];
      for (int i = 16; i < 80; i++) begin
         x = w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16];
         w[i] = {x[30:0], x[31]};
      end
      return w[t];
   endfunction

   task automatic check(input string req, input logic [31:0] exp);
      checks++;
      if (w_o !== exp) begin
         errors++;
         $display("FAIL %s: w_o=%h expected=%h", req, w_o, exp);
      end
   endtask

   task automatic load(input logic [511:0] b, input logic with_next);
      @(negedge clk);
      block_i = b; init_i = 1'b1; next_i = with_next;
      @(negedge clk);
      init_i = 1'b0; next_i = 1'b0; block_i = ~b;
   endtask

   task automatic step();
      next_i = 1'b1;
      @(negedge clk);
      next_i = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 in reset", 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", 32'h0);

      // Vector table walk: every word of every block, then saturation.
      for (int k = 0; k < NBLK; k++) begin
         load(BLOCKS[k], 1'b0);
         for (int t = 0; t < 80; t++) begin
            check((t < 16) ? "R3 loaded word" : "R4 expanded word", ref_w(BLOCKS[k], t));
            next_i = 1'b1;
            @(negedge clk);
         end
         repeat (3) @(negedge clk);
         next_i = 1'b0;
         check("R6 saturate at W79", ref_w(BLOCKS[k], 79));
      end

      // R2: first word right after init.
      load(BLOCKS[3], 1'b0);
      check("R2 word0 after init", BLOCKS[3][511:480]);

      // R5: idle cycles hold the word.
      step(); step();
      repeat (4) @(negedge clk);
      check("R5 idle hold", ref_w(BLOCKS[3], 2));
      step();
      check("R5 single advance", ref_w(BLOCKS[3], 3));

      // R8: restart mid-block after ten rounds.
      repeat (7) step();
      check("R8 precondition round10", ref_w(BLOCKS[3], 10));
      load(BLOCKS[0], 1'b0);
      for (int t = 0; t < 80; t++) begin
         check("R8 restart word", ref_w(BLOCKS[0], t));
         step();
      end

      // R7: init and next together.
      load(BLOCKS[3], 1'b1);
      check("R7 init wins", ref_w(BLOCKS[3], 0));
      step();
      check("R7 then round1", ref_w(BLOCKS[3], 1));

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule